// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the control and status registers for one bank of 32 general-purpose pins, arranged as four ports of eight pins. A simple 32-bit register bus (address, write strobe, write data, combinational read data) reaches every register of every port. From the registers the block drives each pad's output value and output enable. It also brings the pad inputs into the clock domain and exposes them for readback and for a separate edge and level detector.

The detector is a companion block. It receives the synchronized pin levels and each pin's three-bit interrupt type from this block, and it returns one-cycle set pulses that latch into the per-pin interrupt status. Software acknowledges a pin by writing a one to its bit in the clear register. Every writable register also has a masked alias 0x800 bytes higher. In a write to an alias, the upper byte selects which pins change, so a single pin can be updated without a read-modify-write.

Top module: `gpio_bank_regs`

## Requirements
- R1: Byte address fields: bit 11 selects the masked alias, bits [10:7] carry the bank index, bits [6:4] the register group, bits [3:2] the port, and bits [1:0] are ignored. Group codes: 0 configuration, 1 output enable, 2 output, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 interrupt clear. When the bank index differs from the BANK_ID parameter, a write changes nothing and a read returns 0.
- R2: A plain write to configuration, output enable, output, interrupt status or interrupt enable stores write-data bits [7:0]. A plain read returns the register zero-extended.
- R3: A masked write updates pin k only when write-data bit 8+k is 1, and then to write-data bit k. Pins whose mask bit is 0 keep their value.
- R4: The interrupt type register is 24 bits wide. A plain write stores write-data bits [23:0]. A masked write applies the R3 rule to type bits [7:0] only and leaves type bits [23:8] unchanged.
- R5: The input register and pin_sync_o return the pad levels through two flops: a pad change set up before clock edge N is visible after edge N+1.
- R6: pad_out_o bit n equals output-register bit n. pad_oe_o bit n is 1 only when both the configuration bit and the output-enable bit of pin n are 1.
- R7: Writing a 1 to bit k of the plain clear register clears the status of pin k, and writing 0 there has no effect. A set pulse for the same pin in the same cycle wins over the clear.
- R8: A 1 on irq_set_i bit n sets the status of pin n at the next edge, whatever the pin's enable.
- R9: irq_o is 1 exactly when some pin has both its status bit and its enable bit set.
- R10: Reset clears every register, so all interrupt enables are 0, no pad is driven and irq_o is 0.
- R11: Reads of any masked alias and of the clear register return 0. Writes to the input register, to its alias and to the clear alias change nothing.
- R12: int_type_o[24*p +: 24] carries port p's interrupt type register. Pin k of the port uses type bits k, 8+k and 16+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pad_in_i | input | 32 | Asynchronous pad levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_set_i | input | 32 | Per-pin status set pulses from the detector |
| pin_sync_o | output | 32 | Synchronized pin levels for the detector |
| int_type_o | output | 96 | Interrupt type registers of the four ports |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The assertions assume that one bus access arrives per cycle, and that irq_set_i and the bus inputs are already synchronous to clk_i. pad_in_i alone may change at any time. The stimulus changes every input on the falling edge, which keeps it within these assumptions. It mixes directed sequences with a long random phase that aims about a fifth of its accesses at foreign banks. In the random phase, set pulses and clears land on the same pins in the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned GRP_W  = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_CFG  = 3'd0,
    GRP_OE   = 3'd1,
    GRP_OUT  = 3'd2,
    GRP_IN   = 3'd3,
    GRP_STA  = 3'd4,
    GRP_EN   = 3'd5,
    GRP_TYPE = 3'd6,
    GRP_CLR  = 3'd7
  } grp_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= din_i;
      sync_q <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign dout_o = sync_q;

  // R5: two-cycle latency once both flops hold post-reset data
  p_sync_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (dout_o == $past(din_i, 2)))
    else $error("p_sync_lat_r5");
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_ID = 3,
  parameter int unsigned PORTS   = 4,
  parameter int unsigned PORT_W  = 2,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              alias_o,
  output grp_e              grp_o,
  output logic [PORT_W-1:0] port_o,
  output logic [PORTS-1:0]  port_we_o
);
  localparam int unsigned PORT_LSB = 2;
  localparam int unsigned GRP_LSB  = PORT_LSB + PORT_W;
  localparam int unsigned BANK_LSB = GRP_LSB + GRP_W;
  localparam int unsigned ALIAS_B  = BANK_LSB + BANK_W;

  logic [BANK_W-1:0] bank;
  logic [1:0]        unused_byte;

  assign unused_byte = addr_i[1:0];
  assign bank    = addr_i[BANK_LSB +: BANK_W];
  assign hit_o   = (bank == BANK_W'(BANK_ID));
  assign alias_o = addr_i[ALIAS_B];
  assign grp_o   = grp_e'(addr_i[GRP_LSB +: GRP_W]);
  assign port_o  = addr_i[PORT_LSB +: PORT_W];

  for (genvar p = 0; p < PORTS; p++) begin : g_we
    assign port_we_o[p] = we_i && hit_o && (port_o == PORT_W'(p));
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              alias_i,
  input  grp_e              grp_i,
  input  logic [3*PINS-1:0] wdata_i,
  input  logic [PINS-1:0]   set_i,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   cfg_o,
  output logic [PINS-1:0]   oe_o,
  output logic [PINS-1:0]   out_o,
  output logic [PINS-1:0]   sta_o,
  output logic [PINS-1:0]   en_o,
  output logic [3*PINS-1:0] type_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned TYPE_W = 3 * PINS;

  logic [PINS-1:0]   cfg_q, oe_q, out_q, sta_q, en_q;
  logic [TYPE_W-1:0] type_q;
  logic [PINS-1:0]   wmask, wval, clr_bits;
  logic              clr_we;

  assign wmask    = wdata_i[2*PINS-1:PINS];
  assign wval     = wdata_i[PINS-1:0];
  assign clr_we   = wr_en_i && !alias_i && (grp_i == GRP_CLR);
  assign clr_bits = clr_we ? wval : '0;

  function automatic logic [PINS-1:0] upd(input logic [PINS-1:0] old,
                                          input logic              al,
                                          input logic [PINS-1:0]   m,
                                          input logic [PINS-1:0]   v);
    return al ? ((old & ~m) | (v & m)) : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      oe_q   <= '0;
      out_q  <= '0;
      sta_q  <= '0;
      en_q   <= '0;
      type_q <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (grp_i)
          GRP_CFG: cfg_q <= upd(cfg_q, alias_i, wmask, wval);
          GRP_OE:  oe_q  <= upd(oe_q,  alias_i, wmask, wval);
          GRP_OUT: out_q <= upd(out_q, alias_i, wmask, wval);
          GRP_EN:  en_q  <= upd(en_q,  alias_i, wmask, wval);
          GRP_TYPE: begin
            if (alias_i) type_q[PINS-1:0] <= upd(type_q[PINS-1:0], 1'b1, wmask, wval);
            else         type_q <= wdata_i;
          end
          default: ;
        endcase
      end
      // set pulses win over software clear and software status writes
      if (wr_en_i && grp_i == GRP_STA)
        sta_q <= upd(sta_q, alias_i, wmask, wval) | set_i;
      else
        sta_q <= (sta_q & ~clr_bits) | set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!alias_i) begin
      unique case (grp_i)
        GRP_CFG:  rdata_o = DATA_W'(cfg_q);
        GRP_OE:   rdata_o = DATA_W'(oe_q);
        GRP_OUT:  rdata_o = DATA_W'(out_q);
        GRP_IN:   rdata_o = DATA_W'(pin_i);
        GRP_STA:  rdata_o = DATA_W'(sta_q);
        GRP_EN:   rdata_o = DATA_W'(en_q);
        GRP_TYPE: rdata_o = DATA_W'(type_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign cfg_o  = cfg_q;
  assign oe_o   = oe_q;
  assign out_o  = out_q;
  assign sta_o  = sta_q;
  assign en_o   = en_q;
  assign type_o = type_q;

  p_mask_hold_cfg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alias_i && grp_i == GRP_CFG) |=>
      (((cfg_q ^ $past(cfg_q)) & ~$past(wmask)) == '0))
    else $error("p_mask_hold_cfg_r3");

  p_mask_hold_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alias_i && grp_i == GRP_EN) |=>
      (((en_q ^ $past(en_q)) & ~$past(wmask)) == '0))
    else $error("p_mask_hold_en_r3");

  p_type_hi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alias_i && grp_i == GRP_TYPE) |=>
      (type_q[TYPE_W-1:PINS] == $past(type_q[TYPE_W-1:PINS])))
    else $error("p_type_hi_hold_r4");

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we |=> ((sta_q & $past(wval & ~set_i)) == '0))
    else $error("p_clear_r7");

  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sta_q & $past(set_i)) == $past(set_i)))
    else $error("p_set_r8");
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_ID = 3,
  parameter int unsigned PORTS   = 4,
  parameter int unsigned PINS    = 8,
  localparam int unsigned PORT_W = $clog2(PORTS),
  localparam int unsigned ADDR_W = 2 + PORT_W + GRP_W + BANK_W + 1,
  localparam int unsigned NPIN   = PORTS * PINS,
  localparam int unsigned TYPE_W = 3 * PINS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic                    bus_we_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  input  logic [NPIN-1:0]         pad_in_i,
  output logic [NPIN-1:0]         pad_out_o,
  output logic [NPIN-1:0]         pad_oe_o,
  input  logic [NPIN-1:0]         irq_set_i,
  output logic [NPIN-1:0]         pin_sync_o,
  output logic [PORTS*TYPE_W-1:0] int_type_o,
  output logic                    irq_o
);
  logic              hit, alias_acc;
  grp_e              grp;
  logic [PORT_W-1:0] port;
  logic [PORTS-1:0]  port_we;
  logic [DATA_W-1:0] port_rdata [PORTS];
  logic [NPIN-1:0]   cfg, oe, sta, en;
  logic [DATA_W-TYPE_W-1:0] unused_wdata;

  assign unused_wdata = bus_wdata_i[DATA_W-1:TYPE_W];

  gpio_in_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (pad_in_i),
    .dout_o (pin_sync_o)
  );

  gpio_bank_decode #(
    .BANK_ID (BANK_ID),
    .PORTS   (PORTS),
    .PORT_W  (PORT_W),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .hit_o     (hit),
    .alias_o   (alias_acc),
    .grp_o     (grp),
    .port_o    (port),
    .port_we_o (port_we)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port_regs #(.PINS(PINS)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (port_we[p]),
      .alias_i (alias_acc),
      .grp_i   (grp),
      .wdata_i (bus_wdata_i[TYPE_W-1:0]),
      .set_i   (irq_set_i[p*PINS +: PINS]),
      .pin_i   (pin_sync_o[p*PINS +: PINS]),
      .cfg_o   (cfg[p*PINS +: PINS]),
      .oe_o    (oe[p*PINS +: PINS]),
      .out_o   (pad_out_o[p*PINS +: PINS]),
      .sta_o   (sta[p*PINS +: PINS]),
      .en_o    (en[p*PINS +: PINS]),
      .type_o  (int_type_o[p*TYPE_W +: TYPE_W]),
      .rdata_o (port_rdata[p])
    );
  end

  assign bus_rdata_o = hit ? port_rdata[port] : '0;
  assign pad_oe_o    = cfg & oe;
  assign irq_o       = |(sta & en);

  // R1: a write aimed at another bank leaves the pads untouched
  p_foreign_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !hit) |=> ($stable(pad_out_o) && $stable(pad_oe_o)))
    else $error("p_foreign_ignored_r1");

  // R6: a driven pad needs a configured pin
  p_oe_needs_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~cfg) == '0))
    else $error("p_oe_needs_cfg_r6");
endmodule

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BANK = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pin_sync;
  logic [31:0] irq_set = '0;
  logic [95:0] int_type;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [7:0]  m_cfg [4], m_oe [4], m_out [4], m_sta [4], m_en [4];
  logic [23:0] m_typ [4];
  logic [31:0] m_s1, m_s2;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs #(.BANK_ID(BANK)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pad_in_i    (pad_in),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe),
    .irq_set_i   (irq_set),
    .pin_sync_o  (pin_sync),
    .int_type_o  (int_type),
    .irq_o       (irq)
  );

  function automatic logic [11:0] mk(input bit al, input int bank, input int grp, input int port);
    return {al, 4'(bank), 3'(grp), 2'(port), 2'b00};
  endfunction

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [15:0] d);
    return (old & ~d[15:8]) | (d[7:0] & d[15:8]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < 4; q++) begin
        m_cfg[q] = 0; m_oe[q] = 0; m_out[q] = 0; m_sta[q] = 0; m_en[q] = 0; m_typ[q] = 0;
      end
      m_s1 = 0; m_s2 = 0;
    end else begin
      bit hitw, al;
      int g, pt;
      hitw = we && (addr[10:7] == BANK);
      al = addr[11];
      g = int'(addr[6:4]);
      pt = int'(addr[3:2]);
      for (int q = 0; q < 4; q++) begin
        logic [7:0] s;
        s = m_sta[q];
        if (hitw && q == pt) begin
          case (g)
            0: m_cfg[q] = al ? merge(m_cfg[q], wdata[15:0]) : wdata[7:0];
            1: m_oe[q]  = al ? merge(m_oe[q],  wdata[15:0]) : wdata[7:0];
            2: m_out[q] = al ? merge(m_out[q], wdata[15:0]) : wdata[7:0];
            4: s        = al ? merge(s,        wdata[15:0]) : wdata[7:0];
            5: m_en[q]  = al ? merge(m_en[q],  wdata[15:0]) : wdata[7:0];
            6: m_typ[q] = al ? {m_typ[q][23:8], merge(m_typ[q][7:0], wdata[15:0])} : wdata[23:0];
            7: if (!al) s = s & ~wdata[7:0];
            default: ;
          endcase
        end
        m_sta[q] = s | irq_set[8*q +: 8];
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  function automatic logic [31:0] exp_rd();
    int q;
    q = int'(addr[3:2]);
    if (addr[10:7] != BANK || addr[11]) return 0;
    case (int'(addr[6:4]))
      0: return {24'b0, m_cfg[q]};
      1: return {24'b0, m_oe[q]};
      2: return {24'b0, m_out[q]};
      3: return {24'b0, m_s2[8*q +: 8]};
      4: return {24'b0, m_sta[q]};
      5: return {24'b0, m_en[q]};
      6: return {8'b0, m_typ[q]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every output against the model; called on the falling edge
  task automatic compare();
    logic [31:0] e_out, e_oe;
    logic [95:0] e_typ;
    logic        e_irq;
    e_irq = 0;
    for (int q = 0; q < 4; q++) begin
      e_out[8*q +: 8] = m_out[q];
      e_oe[8*q +: 8]  = m_cfg[q] & m_oe[q];
      e_typ[24*q +: 24] = m_typ[q];
      e_irq |= |(m_sta[q] & m_en[q]);
    end
    chk("R6 pad_out", 128'(pad_out), 128'(e_out));
    chk("R6 pad_oe", 128'(pad_oe), 128'(e_oe));
    chk("R9 irq", 128'(irq), 128'(e_irq));
    chk("R5 pin_sync", 128'(pin_sync), 128'(m_s2));
    chk("R12 int_type", 128'(int_type), 128'(e_typ));
    // read path covers R1 R2 R3 R4 R7 R8 R11
    chk("R2 read data", 128'(rdata), 128'(exp_rd()));
  endtask

  task automatic cyc(input logic [11:0] a, input bit w, input logic [31:0] d,
                     input logic [31:0] s, input logic [31:0] p);
    @(negedge clk);
    compare();
    addr = a; we = w; wdata = d; irq_set = s; pad_in = p;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, 0, pad_in);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(a, 1'b0, 0, 0, pad_in);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pad_in = 32'hDEAD_BEEF;
    // R10: outputs idle while held in reset
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    rd(mk(0, BANK, 5, 0));
    rd(mk(0, BANK, 5, 3));

    // R2 plain writes and readback
    wr(mk(0, BANK, 0, 0), 32'hFFFF_FFA5);
    wr(mk(0, BANK, 1, 0), 32'h0000_00F0);
    wr(mk(0, BANK, 2, 0), 32'h0000_003C);
    rd(mk(0, BANK, 0, 0));
    rd(mk(0, BANK, 1, 0));
    // R3 masked output write: clear low nibble only
    wr(mk(1, BANK, 2, 0), 32'h0000_0FF0);
    rd(mk(0, BANK, 2, 0));
    // R11 alias read returns 0
    rd(mk(1, BANK, 2, 0));
    // R4 type plain then masked
    wr(mk(0, BANK, 6, 2), 32'hAB12_3456);
    wr(mk(1, BANK, 6, 2), 32'h0000_F0AA);
    rd(mk(0, BANK, 6, 2));
    // R8 set pulse, R9 irq
    cyc(mk(0, BANK, 4, 1), 1'b0, 0, 32'h0000_8100, pad_in);
    wr(mk(0, BANK, 5, 1), 32'h0000_0001);
    rd(mk(0, BANK, 4, 1));
    // R7 clear with 0 bits ineffective, then clear bit 0 with set on bit 7
    wr(mk(0, BANK, 7, 1), 32'h0000_0000);
    cyc(mk(0, BANK, 7, 1), 1'b1, 32'h0000_0081, 32'h0000_8000, pad_in);
    rd(mk(0, BANK, 4, 1));
    // R11 writes to input and clear alias ignored, clear register reads 0
    wr(mk(0, BANK, 3, 1), 32'h0000_00FF);
    wr(mk(1, BANK, 7, 1), 32'h0000_FFFF);
    rd(mk(0, BANK, 7, 1));
    rd(mk(0, BANK, 4, 1));
    // R1 foreign bank write ignored and reads 0
    wr(mk(0, 5, 2, 0), 32'h0000_00FF);
    rd(mk(0, 5, 2, 0));
    rd(mk(0, BANK, 2, 0));
    // R5 pad change latency
    cyc(mk(0, BANK, 3, 2), 1'b0, 0, 0, 32'h00A5_0000);
    rd(mk(0, BANK, 3, 2));
    rd(mk(0, BANK, 3, 2));
    rd(mk(0, BANK, 3, 2));

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int bk;
      bk = ($urandom % 5 == 0) ? int'($urandom % 16) : BANK;
      cyc(mk(($urandom % 4) == 0, bk, int'($urandom % 8), int'($urandom % 4)),
          $urandom % 2 == 0, $urandom,
          $urandom & $urandom & $urandom,
          ($urandom % 3 == 0) ? $urandom : pad_in);
    end

    // R10 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    we = 1'b0;
    irq_set = 0;
    #1;
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    rd(mk(0, BANK, 5, 2));
    rd(mk(0, BANK, 0, 3));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule